// File: doc/BRIEF.md
# Programmable Frame Sync Generator

This block produces the frame synchronisation strobe for a serial audio port. It runs entirely on the system clock. The bit clock is carried as a one-cycle tick enable, not as a separate clock. The tick comes from one of two sources. The first is an internal divider that fires once every `div_ratio + 1` system clocks. The second is an external bit clock pin, which passes through a flop synchroniser and a rising-edge detector. A frame counter advances on each tick and wraps after `per_field + 1` ticks. The sync strobe is active for the first `wid_field + 1` ticks of each frame.

Two enables control start-up. `gen_en` lets the tick source run. `fs_en` releases the frame counter and the strobe. Software sets `gen_en` first and `fs_en` after it. Both are needed before any sync appears. Dropping either enable returns the strobe to its inactive level, and the next release starts a fresh frame. The strobe leaves the block from a register with the selected polarity applied. A separate one-clock `frame_start` pulse marks the first tick of each frame for downstream logic.

For a 16-bit stereo frame, set `per_field = 31` and `wid_field = 15`. This gives a square frame clock over 32 bit clocks.

Top module: `fsg_top`

## Requirements
- R1: While `rst_n` is low, `fsync` and `frame_start` are 0. From the second clock after release, with either enable low, `fsync` sits at its inactive level, which equals `sync_pol`.
- R2: With `src_sel = 0` (internal) and `gen_en` high, the tick fires once every `div_ratio + 1` system clocks.
- R3: With `src_sel = 1` (external), each rising edge of `ext_bclk` gives exactly one tick. The tick comes after `SYNC_STAGES` synchroniser flops and one edge-detect flop.
- R4: Once running, a frame lasts `per_field + 1` ticks, and `frame_start` pulses once per frame.
- R5: The strobe is active for `wid_field + 1` ticks per frame. When `wid_field >= per_field`, it stays active continuously.
- R6: `sync_pol = 0` makes the active level 1. `sync_pol = 1` makes the active level 0.
- R7: The first tick after both enables are high starts a frame at position zero. `fsync` goes active and `frame_start` pulses one system clock after the counter updates. That is two clocks after the enabling edge when `div_ratio = 0`.
- R8: `fs_en` has no effect while `gen_en` is low. No sync and no `frame_start` appear.
- R9: Dropping either enable clears the counter and the strobe. `fsync` is inactive from the second clock after the drop, and a later release restarts from position zero.
- R10: `frame_start` is a one-clock pulse. It coincides with the first active cycle of `fsync` in each frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gen_en | input | 1 | Generator enable (bit clock source runs) |
| fs_en | input | 1 | Frame sync enable, released after `gen_en` |
| src_sel | input | 1 | Bit clock source: 0 internal divider, 1 external pin |
| ext_bclk | input | 1 | External bit clock pin, asynchronous |
| div_ratio | input | DIV_W | Internal divider, tick every value+1 clocks |
| per_field | input | CNT_W | Frame period minus one, in ticks |
| wid_field | input | CNT_W | Active sync width minus one, in ticks |
| sync_pol | input | 1 | 0 active-high strobe, 1 active-low strobe |
| fsync | output | 1 | Registered frame sync strobe |
| frame_start | output | 1 | One-clock pulse at the start of each frame |

## Verification
The assertions assume the following about the configuration inputs:
- `per_field` is never lowered below the current count while the frame counter runs.
- `sync_pol` is steady whenever a `frame_start` is checked.
- `div_ratio` changes only while the generator is off.

The stimulus respects these assumptions. It changes the period, width and polarity only while `fs_en` is low, and the divider only while `gen_en` is low. It drives the external pin with a slow square wave of six system clocks per bit, well inside the synchroniser's rate limit.

// File: rtl/fsg_pkg.sv
package fsg_pkg;
  localparam int unsigned FSG_CNT_W       = 8;
  localparam int unsigned FSG_DIV_W       = 8;
  localparam int unsigned FSG_SYNC_STAGES = 2;

  typedef enum logic {
    BCLK_INTERNAL = 1'b0,
    BCLK_EXTERNAL = 1'b1
  } bclk_src_e;
endpackage

// File: rtl/fsg_bclk_src.sv
module fsg_bclk_src
  import fsg_pkg::*;
#(
  parameter int unsigned DIV_W       = FSG_DIV_W,
  parameter int unsigned SYNC_STAGES = FSG_SYNC_STAGES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gen_en,
  input  logic             src_sel,
  input  logic [DIV_W-1:0] div_ratio,
  input  logic             ext_pin,
  output logic             tick_o
);
  localparam int unsigned LAST = SYNC_STAGES - 1;

  bclk_src_e        src;
  logic [DIV_W-1:0] dcnt_q, dcnt_d;
  logic [LAST:0]    sync_q, sync_d;
  logic             prev_q;
  logic             int_tick, ext_tick;

  assign src = bclk_src_e'(src_sel);

  // synchroniser chain for the asynchronous external bit clock
  assign sync_d[0] = ext_pin;
  for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_sync
    assign sync_d[g] = sync_q[g-1];
  end

  // divider next state: free-running only while the generator is enabled
  always_comb begin
    if (!gen_en)                dcnt_d = '0;
    else if (dcnt_q == div_ratio) dcnt_d = '0;
    else                        dcnt_d = dcnt_q + 1'b1;
  end

  assign int_tick = gen_en && (dcnt_q == div_ratio);
  assign ext_tick = gen_en && sync_q[LAST] && !prev_q;

  always_comb begin
    case (src)
      BCLK_EXTERNAL: tick_o = ext_tick;
      default:       tick_o = int_tick;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dcnt_q <= '0;
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      dcnt_q <= dcnt_d;
      sync_q <= sync_d;
      prev_q <= sync_q[LAST];
    end
  end
endmodule

// File: rtl/fsg_frame_ctr.sv
module fsg_frame_ctr
  import fsg_pkg::*;
#(
  parameter int unsigned CNT_W = FSG_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] per_field,
  input  logic [CNT_W-1:0] wid_field,
  output logic [CNT_W-1:0] pos_o,
  output logic             act_o,
  output logic             start_o
);
  logic [CNT_W-1:0] pos_q, pos_d, pos_nx;
  logic             primed_q, primed_d;
  logic             act_q, act_d;
  logic             start_q, start_d;

  // position the next tick moves to; first tick after release is zero
  always_comb begin
    if (!primed_q)               pos_nx = '0;
    else if (pos_q >= per_field) pos_nx = '0;
    else                         pos_nx = pos_q + 1'b1;
  end

  always_comb begin
    pos_d    = pos_q;
    primed_d = primed_q;
    act_d    = act_q;
    start_d  = 1'b0;
    if (!run) begin
      pos_d    = '0;
      primed_d = 1'b0;
      act_d    = 1'b0;
    end else if (tick) begin
      pos_d    = pos_nx;
      primed_d = 1'b1;
      act_d    = (pos_nx <= wid_field);
      start_d  = (pos_nx == '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q    <= '0;
      primed_q <= 1'b0;
      act_q    <= 1'b0;
      start_q  <= 1'b0;
    end else begin
      pos_q    <= pos_d;
      primed_q <= primed_d;
      act_q    <= act_d;
      start_q  <= start_d;
    end
  end

  assign pos_o   = pos_q;
  assign act_o   = act_q;
  assign start_o = start_q;
endmodule

// File: rtl/fsg_sync_out.sv
module fsg_sync_out (
  input  logic clk,
  input  logic rst_n,
  input  logic act,
  input  logic start,
  input  logic pol,
  output logic fsync_o,
  output logic start_o
);
  logic fs_q, fs_d;
  logic st_q;

  assign fs_d = pol ? !act : act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_q <= 1'b0;
      st_q <= 1'b0;
    end else begin
      fs_q <= fs_d;
      st_q <= start;
    end
  end

  assign fsync_o = fs_q;
  assign start_o = st_q;
endmodule

// File: rtl/fsg_top.sv
module fsg_top
  import fsg_pkg::*;
#(
  parameter int unsigned CNT_W       = FSG_CNT_W,
  parameter int unsigned DIV_W       = FSG_DIV_W,
  parameter int unsigned SYNC_STAGES = FSG_SYNC_STAGES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gen_en,
  input  logic             fs_en,
  input  logic             src_sel,
  input  logic             ext_bclk,
  input  logic [DIV_W-1:0] div_ratio,
  input  logic [CNT_W-1:0] per_field,
  input  logic [CNT_W-1:0] wid_field,
  input  logic             sync_pol,
  output logic             fsync,
  output logic             frame_start
);
  logic             bclk_tick;
  logic             frame_run;
  logic [CNT_W-1:0] frame_pos;
  logic             frame_act;
  logic             frame_first;

  // frame sync only runs once the generator is also released
  assign frame_run = gen_en && fs_en;

  fsg_bclk_src #(.DIV_W(DIV_W), .SYNC_STAGES(SYNC_STAGES)) u_src (
    .clk      (clk),
    .rst_n    (rst_n),
    .gen_en   (gen_en),
    .src_sel  (src_sel),
    .div_ratio(div_ratio),
    .ext_pin  (ext_bclk),
    .tick_o   (bclk_tick)
  );

  fsg_frame_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (frame_run),
    .tick     (bclk_tick),
    .per_field(per_field),
    .wid_field(wid_field),
    .pos_o    (frame_pos),
    .act_o    (frame_act),
    .start_o  (frame_first)
  );

  fsg_sync_out u_out (
    .clk    (clk),
    .rst_n  (rst_n),
    .act    (frame_act),
    .start  (frame_first),
    .pol    (sync_pol),
    .fsync_o(fsync),
    .start_o(frame_start)
  );
endmodule

// File: rtl/fsg_checker.sv
module fsg_checker #(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned DIV_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             gen_en,
  input logic             fs_en,
  input logic             src_sel,
  input logic [DIV_W-1:0] div_ratio,
  input logic [CNT_W-1:0] per_field,
  input logic             sync_pol,
  input logic             tick,
  input logic [CNT_W-1:0] pos,
  input logic             act,
  input logic             fsync,
  input logic             frame_start
);
  // R9
  stop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(gen_en && fs_en) |=> (!act && pos == '0));

  // R4
  pos_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pos <= per_field);

  // R10
  start_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && $stable(sync_pol)) |-> (fsync != sync_pol));

  // R2
  int_tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !src_sel && div_ratio != '0 && $stable(div_ratio)) |=> !tick);

  // R8
  gen_gates_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_en |=> !act);
endmodule

bind fsg_top fsg_checker #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .gen_en     (gen_en),
  .fs_en      (fs_en),
  .src_sel    (src_sel),
  .div_ratio  (div_ratio),
  .per_field  (per_field),
  .sync_pol   (sync_pol),
  .tick       (bclk_tick),
  .pos        (frame_pos),
  .act        (frame_act),
  .fsync      (fsync),
  .frame_start(frame_start)
);

// File: tb/tb_fsg_top.sv
module tb_fsg_top;
  localparam int CNT_W = 8;
  localparam int DIV_W = 8;
  localparam int SYNC  = 2;

  logic clk = 1'b0;
  logic rst_n, gen_en, fs_en, src_sel, ext_bclk, sync_pol;
  logic [DIV_W-1:0] div_ratio;
  logic [CNT_W-1:0] per_field, wid_field;
  logic fsync, frame_start;

  int checks = 0;
  int failures = 0;
  string cur_req = "R1";
  bit done = 0;
  bit ext_run = 0;
  int ext_cnt = 0;

  always #10 clk = !clk;

  fsg_top #(.CNT_W(CNT_W), .DIV_W(DIV_W), .SYNC_STAGES(SYNC)) dut (
    .clk(clk), .rst_n(rst_n), .gen_en(gen_en), .fs_en(fs_en),
    .src_sel(src_sel), .ext_bclk(ext_bclk), .div_ratio(div_ratio),
    .per_field(per_field), .wid_field(wid_field), .sync_pol(sync_pol),
    .fsync(fsync), .frame_start(frame_start)
  );

  task automatic chk(input bit ok, input string req, input int act_v, input int exp_v);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act_v, exp_v, $time);
    end
  endtask

  // behavioural reference model, updated each rising edge
  int m_dcnt, m_pos;
  bit m_sy[SYNC];
  bit m_prev, m_primed, m_act, m_st, m_fs, m_fst;

  always @(posedge clk or negedge rst_n) begin : model
    bit t;
    int nx;
    if (!rst_n) begin
      m_dcnt = 0; m_pos = 0; m_prev = 0; m_primed = 0;
      m_act = 0; m_st = 0; m_fs = 0; m_fst = 0;
      for (int i = 0; i < SYNC; i++) m_sy[i] = 0;
    end else begin
      t = gen_en && (src_sel ? (m_sy[SYNC-1] && !m_prev) : (m_dcnt == int'(div_ratio)));
      m_fs  = m_act ^ sync_pol;
      m_fst = m_st;
      m_prev = m_sy[SYNC-1];
      for (int i = SYNC-1; i > 0; i--) m_sy[i] = m_sy[i-1];
      m_sy[0] = ext_bclk;
      m_dcnt = !gen_en ? 0 : ((m_dcnt == int'(div_ratio)) ? 0 : m_dcnt + 1);
      if (!(gen_en && fs_en)) begin
        m_primed = 0; m_pos = 0; m_act = 0; m_st = 0;
      end else if (t) begin
        nx = !m_primed ? 0 : ((m_pos >= int'(per_field)) ? 0 : m_pos + 1);
        m_primed = 1; m_pos = nx;
        m_act = (nx <= int'(wid_field));
        m_st = (nx == 0);
      end else begin
        m_st = 0;
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(fsync == m_fs, {cur_req, " fsync vs model"}, int'(fsync), int'(m_fs));
      chk(frame_start == m_fst, {cur_req, " frame_start vs model"}, int'(frame_start), int'(m_fst));
    end
  end

  // external bit clock: toggles every 3 system clocks
  always @(negedge clk) begin
    if (ext_run) begin
      ext_cnt++;
      if (ext_cnt == 3) begin
        ext_cnt = 0;
        ext_bclk = !ext_bclk;
      end
    end
  end

  task automatic count_win(input int n, output int act_n, output int st_n);
    act_n = 0; st_n = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (fsync != sync_pol) act_n++;
      if (frame_start) begin
        st_n++;
        // R10: pulse lines up with an active strobe
        chk(fsync != sync_pol, "R10 start with active sync", int'(fsync), int'(!sync_pol));
      end
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_up();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1;
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      finish_up();
    end
  end

  initial begin
    int a, s;
    rst_n = 0; gen_en = 0; fs_en = 0; src_sel = 0; ext_bclk = 0; sync_pol = 0;
    div_ratio = '0; per_field = 8'd7; wid_field = 8'd2;
    wait_cyc(3);
    chk(fsync == 0 && frame_start == 0, "R1 in reset", int'(fsync), 0);
    #1 rst_n = 1;
    wait_cyc(2);
    chk(fsync == 0, "R1 idle level pol0", int'(fsync), 0);
    chk(frame_start == 0, "R1 idle start", int'(frame_start), 0);
    #1 sync_pol = 1;
    wait_cyc(3);
    chk(fsync == 1, "R1 idle level pol1", int'(fsync), 1);
    #1 sync_pol = 0;

    // R8: frame enable without generator
    cur_req = "R8";
    #1 fs_en = 1;
    count_win(30, a, s);
    chk(a == 0, "R8 active cycles", a, 0);
    chk(s == 0, "R8 frame starts", s, 0);
    #1 fs_en = 0;

    // R7: first tick after release starts at position zero
    cur_req = "R7";
    #1 gen_en = 1;
    wait_cyc(5);
    #1 fs_en = 1;
    @(negedge clk);
    chk(frame_start == 0, "R7 one clock before", int'(frame_start), 0);
    @(negedge clk);
    chk(frame_start == 1, "R7 first start", int'(frame_start), 1);
    chk(fsync == 1, "R7 first sync active", int'(fsync), 1);

    // R2/R4/R5: div=1, per=7, wid=2 -> 16-clock frame, 6 active clocks
    cur_req = "R4";
    #1 fs_en = 0; gen_en = 0;
    wait_cyc(2);
    #1 div_ratio = 8'd1; gen_en = 1;
    wait_cyc(2);
    #1 fs_en = 1;
    wait_cyc(40);
    count_win(64, a, s);
    chk(s == 4, "R4 starts per 64 clocks", s, 4);
    chk(a == 24, "R5 active clocks per 64", a, 24);
    chk(a + (64 - a) == 64 && s * 16 == 64, "R2 divider period", s * 16, 64);

    // R9: dropping the frame enable
    cur_req = "R9";
    #1 fs_en = 0;
    wait_cyc(2);
    chk(fsync == 0, "R9 inactive after drop", int'(fsync), 0);
    count_win(20, a, s);
    chk(s == 0, "R9 no starts while stopped", s, 0);
    #1 gen_en = 0;

    // R6: active-low strobe
    cur_req = "R6";
    wait_cyc(2);
    #1 sync_pol = 1; gen_en = 1;
    wait_cyc(2);
    #1 fs_en = 1;
    wait_cyc(40);
    count_win(64, a, s);
    chk(a == 24, "R6 low cycles with pol1", a, 24);
    chk(s == 4, "R6 starts with pol1", s, 4);
    #1 fs_en = 0; gen_en = 0;
    wait_cyc(2);
    #1 sync_pol = 0;

    // R5: width beyond period keeps the strobe on
    cur_req = "R5";
    #1 div_ratio = '0; per_field = 8'd3; wid_field = 8'd5; gen_en = 1;
    wait_cyc(2);
    #1 fs_en = 1;
    wait_cyc(20);
    count_win(32, a, s);
    chk(a == 32, "R5 continuous active", a, 32);
    chk(s == 8, "R4 starts with per=3 div=0", s, 8);
    #1 fs_en = 0; gen_en = 0;
    wait_cyc(2);

    // R3: external bit clock, 6 clocks per bit, per=3, wid=1
    cur_req = "R3";
    #1 src_sel = 1; per_field = 8'd3; wid_field = 8'd1;
    ext_run = 1;
    #1 gen_en = 1;
    wait_cyc(4);
    #1 fs_en = 1;
    wait_cyc(60);
    count_win(48, a, s);
    chk(s == 2, "R3 starts per 48 clocks", s, 2);
    chk(a == 24, "R3 active clocks per 48", a, 24);

    done = 1;
    finish_up();
  end
endmodule